// File: doc/BRIEF.md
# Pipelined Three-Channel Color Matrix Converter

This block maps one three-component video sample per clock from one color space into another. Each output channel is a weighted sum of the three input channels plus a fixed offset. The weights form a 3x3 matrix, so one block can serve RGB to YCbCr, YCbCr back to RGB, RGB to YUV or RGB to YIQ. All weights, offsets, per-channel number formats and per-channel output limits are fixed at elaboration time through parameters. By default the block converts studio-range RGB to standard-definition YCbCr.

A pixel enters on `in_c0..in_c2` together with `in_vld`. Six clock cycles later the converted pixel leaves on `out_c0..out_c2`, and `out_vld` is `in_vld` delayed by the same six cycles. The pipeline accepts a new pixel on every cycle and never stalls, so it fits directly into a streaming video path.

Top module: `color_matrix_conv`

## Requirements
- R1: Output channel k equals M[k][0]*in_c0 + M[k][1]*in_c1 + M[k][2]*in_c2 + offset_k. M is parameter `COEF_MILLI` (thousandths, row-major by output channel). Each weight is first quantized to the nearest multiple of 2^-(COEF_W-3), which gives a signed fixed-point word with two integer bits.
- R2: A sample presented with `in_vld` in clock cycle c appears on the outputs in cycle c+6. `out_vld` is `in_vld` delayed by exactly six cycles, so every valid run keeps its length and its gaps.
- R3: `OFFSET_MILLI[k]` is expressed in 8-bit sample units (thousandths). It is multiplied by 2^(DIN_W-8) before it is added.
- R4: The sum is scaled by 2^(DOUT_W-DIN_W) and then rounded to the nearest output step, with exact halves rounded upward.
- R5: Bit k of `IN_SIGNED` set means input channel k is two's complement. Clear means it is unsigned and zero-extended.
- R6: Output channel k is saturated into [max(OUT_MIN[k], type minimum), min(OUT_MAX[k], type maximum)]. The type range is 0..2^DOUT_W-1 for an unsigned channel and -2^(DOUT_W-1)..2^(DOUT_W-1)-1 for a signed one.
- R7: Bit k of `OUT_SIGNED` set means output channel k is emitted as DOUT_W-bit two's complement. Clear means it is emitted as unsigned binary.
- R8: While `rst_n` is low, asynchronously, `out_vld` and all output channels are zero.
- R9: The data path advances on every clock regardless of `in_vld`. With `in_vld` low, the data outputs still show the conversion of the inputs from six cycles earlier, while `out_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample qualifier |
| in_c0 | input | DIN_W | Input channel 0 (e.g. R or Y) |
| in_c1 | input | DIN_W | Input channel 1 (e.g. G or Cb) |
| in_c2 | input | DIN_W | Input channel 2 (e.g. B or Cr) |
| out_vld | output | 1 | Output sample qualifier |
| out_c0 | output | DOUT_W | Converted channel 0 |
| out_c1 | output | DOUT_W | Converted channel 1 |
| out_c2 | output | DOUT_W | Converted channel 2 |

## Verification
The latency and run-shape properties assume that `in_vld` carries a defined value on every clock from the first edge after reset. The stimulus therefore drives every input to zero during reset and between scenarios, and it changes inputs only on falling edges. The range properties assume the parameter limits describe a non-empty window, with OUT_MIN at or below OUT_MAX after intersection with the output type. Both bench configurations are chosen so that this holds. Saturation is reached only through the clamp and never through accumulator wrap, because the stimulus keeps to legal input codes for each channel's declared signedness.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    // Pipeline depth from input sample to output register.
    localparam int unsigned CMC_LATENCY = 6;

    // Round (value_milli / 1000) * 2^shift to nearest, halves away from zero.
    function automatic longint fix_round(input longint value_milli, input int shift);
        longint scaled;
        scaled = value_milli * (longint'(1) <<< shift);
        if (scaled >= 0)
            return (scaled + 500) / 1000;
        else
            return -((-scaled + 500) / 1000);
    endfunction

    // Upper saturation bound: user limit intersected with the output type range.
    function automatic int chan_hi(input int width, input bit is_signed, input int limit);
        int type_max;
        type_max = is_signed ? ((1 << (width - 1)) - 1) : ((1 << width) - 1);
        return (limit < type_max) ? limit : type_max;
    endfunction

    // Lower saturation bound: user limit intersected with the output type range.
    function automatic int chan_lo(input int width, input bit is_signed, input int limit);
        int type_min;
        type_min = is_signed ? -(1 << (width - 1)) : 0;
        return (limit > type_min) ? limit : type_min;
    endfunction

endpackage

// File: rtl/cmc_in_stage.sv
module cmc_in_stage #(
    parameter int       DIN_W     = 8,
    parameter bit [2:0] IN_SIGNED = 3'b000,
    localparam int      XW        = DIN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIN_W-1:0]    in_c0,
    input  logic [DIN_W-1:0]    in_c1,
    input  logic [DIN_W-1:0]    in_c2,
    output logic [2:0][XW-1:0]  x_o
);

    typedef struct packed {
        logic [2:0][XW-1:0] x;
    } in_state_t;

    in_state_t state_d, state_q;
    logic [2:0][DIN_W-1:0] raw;
    logic [2:0][XW-1:0]    ext;

    assign raw = {in_c2, in_c1, in_c0};

    // Per-channel extension into a common signed width.
    for (genvar ch = 0; ch < 3; ch++) begin : g_ext
        if (IN_SIGNED[ch]) begin : g_sx
            assign ext[ch] = {raw[ch][DIN_W-1], raw[ch]};
        end else begin : g_zx
            assign ext[ch] = {1'b0, raw[ch]};
        end
    end

    always_comb begin
        state_d   = state_q;
        state_d.x = ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign x_o = state_q.x;

endmodule

// File: rtl/cmc_mac_lane.sv
module cmc_mac_lane #(
    parameter int     XW     = 9,
    parameter int     COEF_W = 11,
    parameter int     ACC_W  = 23,
    parameter longint K0     = 0,
    parameter longint K1     = 0,
    parameter longint K2     = 0,
    parameter longint OFF    = 0,
    localparam int    PROD_W = XW + COEF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0][XW-1:0]      x_i,
    output logic signed [ACC_W-1:0] acc_o
);

    localparam logic signed [COEF_W-1:0] C0    = COEF_W'(K0);
    localparam logic signed [COEF_W-1:0] C1    = COEF_W'(K1);
    localparam logic signed [COEF_W-1:0] C2    = COEF_W'(K2);
    localparam logic signed [ACC_W-1:0]  OFF_A = ACC_W'(OFF);

    typedef struct packed {
        logic [PROD_W-1:0] p0;
        logic [PROD_W-1:0] p1;
        logic [PROD_W-1:0] p2;
        logic [ACC_W-1:0]  sa;
        logic [ACC_W-1:0]  sb;
        logic [ACC_W-1:0]  acc;
    } mac_state_t;

    mac_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // stage 2: three products
        state_d.p0 = PROD_W'($signed(x_i[0])) * PROD_W'(C0);
        state_d.p1 = PROD_W'($signed(x_i[1])) * PROD_W'(C1);
        state_d.p2 = PROD_W'($signed(x_i[2])) * PROD_W'(C2);
        // stage 3: pairwise sums, offset and rounding bias folded into one term
        state_d.sa = ACC_W'($signed(state_q.p0)) + ACC_W'($signed(state_q.p1));
        state_d.sb = ACC_W'($signed(state_q.p2)) + OFF_A;
        // stage 4: full accumulation
        state_d.acc = state_q.sa + state_q.sb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign acc_o = $signed(state_q.acc);

endmodule

// File: rtl/cmc_sat_lane.sv
module cmc_sat_lane #(
    parameter int ACC_W  = 23,
    parameter int SHIFT  = 8,
    parameter int DOUT_W = 8,
    parameter int HI     = 255,
    parameter int LO     = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_i,
    output logic [DOUT_W-1:0]       dout_o
);

    localparam logic signed [ACC_W-1:0] HI_A = ACC_W'(HI);
    localparam logic signed [ACC_W-1:0] LO_A = ACC_W'(LO);
    localparam logic [DOUT_W-1:0]       HI_D = DOUT_W'(HI);
    localparam logic [DOUT_W-1:0]       LO_D = DOUT_W'(LO);

    typedef struct packed {
        logic              over;
        logic              under;
        logic [DOUT_W-1:0] val;
        logic [DOUT_W-1:0] dout;
    } sat_state_t;

    sat_state_t state_d, state_q;
    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        state_d = state_q;
        shifted = acc_i >>> SHIFT;
        // stage 5: drop fraction, compare against the window
        state_d.over  = (shifted > HI_A);
        state_d.under = (shifted < LO_A);
        state_d.val   = shifted[DOUT_W-1:0];
        // stage 6: select and register the output word
        if (state_q.over)       state_d.dout = HI_D;
        else if (state_q.under) state_d.dout = LO_D;
        else                    state_d.dout = state_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dout_o = state_q.dout;

endmodule

// File: rtl/color_matrix_conv.sv
module color_matrix_conv #(
    parameter int       DIN_W           = 8,
    parameter int       DOUT_W          = 8,
    parameter int       COEF_W          = 11,
    parameter bit [2:0] IN_SIGNED       = 3'b000,
    parameter bit [2:0] OUT_SIGNED      = 3'b000,
    parameter int       COEF_MILLI [9]  = '{299, 587, 114, -172, -339, 511, 511, -428, -83},
    parameter int       OFFSET_MILLI [3] = '{0, 128000, 128000},
    parameter int       OUT_MAX [3]     = '{255, 255, 255},
    parameter int       OUT_MIN [3]     = '{0, 0, 0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DIN_W-1:0]  in_c0,
    input  logic [DIN_W-1:0]  in_c1,
    input  logic [DIN_W-1:0]  in_c2,
    output logic              out_vld,
    output logic [DOUT_W-1:0] out_c0,
    output logic [DOUT_W-1:0] out_c1,
    output logic [DOUT_W-1:0] out_c2
);

    localparam int FRAC_W    = COEF_W - 3;
    localparam int XW        = DIN_W + 1;
    localparam int PROD_W    = XW + COEF_W;
    localparam int ACC_W     = PROD_W + 3;
    localparam int SHIFT     = FRAC_W + DIN_W - DOUT_W;
    localparam int OFF_SHIFT = FRAC_W + DIN_W - 8;
    localparam int LAT       = cmc_pkg::CMC_LATENCY;
    localparam longint RND   = longint'(1) <<< (SHIFT - 1);

    typedef struct packed {
        logic [LAT-1:0] vld;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic [2:0][XW-1:0]    xs;
    logic signed [ACC_W-1:0] acc [3];
    logic [DOUT_W-1:0]     res [3];

    cmc_in_stage #(
        .DIN_W     (DIN_W),
        .IN_SIGNED (IN_SIGNED)
    ) in_stage_i (
        .clk   (clk),
        .rst_n (rst_n),
        .in_c0 (in_c0),
        .in_c1 (in_c1),
        .in_c2 (in_c2),
        .x_o   (xs)
    );

    for (genvar k = 0; k < 3; k++) begin : g_lane
        cmc_mac_lane #(
            .XW     (XW),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W),
            .K0     (cmc_pkg::fix_round(longint'(COEF_MILLI[3*k+0]), FRAC_W)),
            .K1     (cmc_pkg::fix_round(longint'(COEF_MILLI[3*k+1]), FRAC_W)),
            .K2     (cmc_pkg::fix_round(longint'(COEF_MILLI[3*k+2]), FRAC_W)),
            .OFF    (cmc_pkg::fix_round(longint'(OFFSET_MILLI[k]), OFF_SHIFT) + RND)
        ) mac_i (
            .clk   (clk),
            .rst_n (rst_n),
            .x_i   (xs),
            .acc_o (acc[k])
        );

        cmc_sat_lane #(
            .ACC_W  (ACC_W),
            .SHIFT  (SHIFT),
            .DOUT_W (DOUT_W),
            .HI     (cmc_pkg::chan_hi(DOUT_W, OUT_SIGNED[k], OUT_MAX[k])),
            .LO     (cmc_pkg::chan_lo(DOUT_W, OUT_SIGNED[k], OUT_MIN[k]))
        ) sat_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .acc_i  (acc[k]),
            .dout_o (res[k])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = {ctl_q.vld[LAT-2:0], in_vld};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign out_vld = ctl_q.vld[LAT-1];
    assign out_c0  = res[0];
    assign out_c1  = res[1];
    assign out_c2  = res[2];

endmodule

// File: rtl/cmc_checks.sv
module cmc_checks #(
    parameter int       DOUT_W     = 8,
    parameter bit [2:0] OUT_SIGNED = 3'b000,
    parameter int       OUT_MAX [3] = '{255, 255, 255},
    parameter int       OUT_MIN [3] = '{0, 0, 0}
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic              out_vld,
    input logic [DOUT_W-1:0] out_c0,
    input logic [DOUT_W-1:0] out_c1,
    input logic [DOUT_W-1:0] out_c2
);

    localparam int HI0 = cmc_pkg::chan_hi(DOUT_W, OUT_SIGNED[0], OUT_MAX[0]);
    localparam int HI1 = cmc_pkg::chan_hi(DOUT_W, OUT_SIGNED[1], OUT_MAX[1]);
    localparam int HI2 = cmc_pkg::chan_hi(DOUT_W, OUT_SIGNED[2], OUT_MAX[2]);
    localparam int LO0 = cmc_pkg::chan_lo(DOUT_W, OUT_SIGNED[0], OUT_MIN[0]);
    localparam int LO1 = cmc_pkg::chan_lo(DOUT_W, OUT_SIGNED[1], OUT_MIN[1]);
    localparam int LO2 = cmc_pkg::chan_lo(DOUT_W, OUT_SIGNED[2], OUT_MIN[2]);

    logic [3:0] since_rst;
    int v0, v1, v2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 4'd8) since_rst <= since_rst + 4'd1;
    end

    always_comb begin
        v0 = OUT_SIGNED[0] ? int'($signed(out_c0)) : int'({1'b0, out_c0});
        v1 = OUT_SIGNED[1] ? int'($signed(out_c1)) : int'({1'b0, out_c1});
        v2 = OUT_SIGNED[2] ? int'($signed(out_c2)) : int'({1'b0, out_c2});
    end

    // R8: reset holds qualifier and data at zero
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |-> (!out_vld && out_c0 == '0 && out_c1 == '0 && out_c2 == '0));

    // R2: qualifier delayed by exactly six cycles
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd6) |-> (out_vld == $past(in_vld, 6)));

    // R2: a run starts at the output exactly where it started at the input
    assert_run_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd7) && $rose(out_vld)) |-> ($past(in_vld, 6) && !$past(in_vld, 7)));

    // R6: every qualified output lies inside its channel window
    assert_range_c0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (v0 >= LO0 && v0 <= HI0));
    assert_range_c1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (v1 >= LO1 && v1 <= HI1));
    assert_range_c2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (v2 >= LO2 && v2 <= HI2));

endmodule

bind color_matrix_conv cmc_checks #(
    .DOUT_W     (DOUT_W),
    .OUT_SIGNED (OUT_SIGNED),
    .OUT_MAX    (OUT_MAX),
    .OUT_MIN    (OUT_MIN)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_c0  (out_c0),
    .out_c1  (out_c1),
    .out_c2  (out_c2)
);

// File: tb/color_matrix_conv_tb_top.sv
module color_matrix_conv_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    // default configuration: 8-bit studio RGB to YCbCr
    logic       a_vld = 1'b0;
    logic [7:0] a_c0 = '0, a_c1 = '0, a_c2 = '0;
    logic       a_ovld;
    logic [7:0] a_o0, a_o1, a_o2;

    // second configuration: 10-bit, mixed signedness, custom windows
    logic       b_vld = 1'b0;
    logic [9:0] b_c0 = '0, b_c1 = '0, b_c2 = '0;
    logic       b_ovld;
    logic [9:0] b_o0, b_o1, b_o2;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    color_matrix_conv dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (a_vld),
        .in_c0   (a_c0),
        .in_c1   (a_c1),
        .in_c2   (a_c2),
        .out_vld (a_ovld),
        .out_c0  (a_o0),
        .out_c1  (a_o1),
        .out_c2  (a_o2)
    );

    color_matrix_conv #(
        .DIN_W        (10),
        .DOUT_W       (10),
        .COEF_W       (14),
        .IN_SIGNED    (3'b010),
        .OUT_SIGNED   (3'b100),
        .COEF_MILLI   ('{1000, 0, 0, 0, 1000, 0, 0, -1000, 500}),
        .OFFSET_MILLI ('{0, 0, 10000}),
        .OUT_MAX      ('{600, 1023, 500}),
        .OUT_MIN      ('{100, 0, -450})
    ) dut_sg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (b_vld),
        .in_c0   (b_c0),
        .in_c1   (b_c1),
        .in_c2   (b_c2),
        .out_vld (b_ovld),
        .out_c0  (b_o0),
        .out_c1  (b_o1),
        .out_c2  (b_o2)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference for the default matrix, from R1/R3/R4/R6 with COEF_W=11 (8 fraction bits).
    function automatic int q8(input real c);
        return $rtoi($floor(c * 256.0 + 0.5));
    endfunction

    function automatic int model_std(input int ch, input int r, input int g, input int b);
        real ka, kb, kc;
        int off;
        longint s;
        int v;
        case (ch)
            0:       begin ka = 0.299;  kb = 0.587;  kc = 0.114;  off = 0;   end
            1:       begin ka = -0.172; kb = -0.339; kc = 0.511;  off = 128; end
            default: begin ka = 0.511;  kb = -0.428; kc = -0.083; off = 128; end
        endcase
        s = longint'(q8(ka)) * r + longint'(q8(kb)) * g + longint'(q8(kc)) * b
            + longint'(off) * 256 + 128;
        v = int'(s >>> 8);
        if (v > 255) v = 255;
        if (v < 0)   v = 0;
        return v;
    endfunction

    // Reference for the second configuration (14-bit weights, 11 fraction bits, 10-bit data).
    function automatic int model_sg(input int ch, input int d0, input int d1raw, input int d2);
        int x1;
        longint s;
        int v;
        x1 = (d1raw >= 512) ? d1raw - 1024 : d1raw;
        case (ch)
            0: begin
                v = d0;
                if (v > 600) v = 600;
                if (v < 100) v = 100;
            end
            1: begin
                v = x1;
                if (v < 0) v = 0;
            end
            default: begin
                s = -longint'(2048) * x1 + longint'(1024) * d2 + 81920 + 1024;
                v = int'(s >>> 11);
                if (v > 500)  v = 500;
                if (v < -450) v = -450;
                v = v & 1023;
            end
        endcase
        return v;
    endfunction

    task automatic drive_a(input int r, input int g, input int b, input bit v);
        a_c0 = 8'(r); a_c1 = 8'(g); a_c2 = 8'(b); a_vld = v;
    endtask

    task automatic drive_b(input int d0, input int d1, input int d2, input bit v);
        b_c0 = 10'(d0); b_c1 = 10'(d1); b_c2 = 10'(d2); b_vld = v;
    endtask

    // R8: outputs are zero in reset and just after release
    task automatic t_reset();
        rst_n = 1'b0;
        drive_a(0, 0, 0, 0);
        drive_b(0, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R8", "vld in reset", int'(a_ovld), 0);
        chk("R8", "c1 in reset", int'(a_o1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "vld after release", int'(a_ovld), 0);
        chk("R8", "c2 after release", int'(a_o2), 0);
        repeat (7) @(negedge clk);
    endtask

    // R1/R3/R4/R6: back-to-back pixels, each checked six cycles later
    task automatic t_stream_std();
        int pr [8] = '{0, 255, 255, 0, 0, 255, 16, 100};
        int pg [8] = '{0, 255, 0, 255, 0, 255, 128, 50};
        int pb [8] = '{0, 255, 0, 0, 255, 0, 235, 200};
        for (int i = 0; i < 14; i++) begin
            if (i >= 6) begin
                chk("R2", "stream vld", int'(a_ovld), 1);
                chk("R1", "stream c0", int'(a_o0), model_std(0, pr[i-6], pg[i-6], pb[i-6]));
                chk("R3", "stream c1", int'(a_o1), model_std(1, pr[i-6], pg[i-6], pb[i-6]));
                chk("R4", "stream c2", int'(a_o2), model_std(2, pr[i-6], pg[i-6], pb[i-6]));
            end
            if (i < 8) drive_a(pr[i], pg[i], pb[i], 1);
            else       drive_a(0, 0, 0, 0);
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // R6: explicit over- and underflow of the default window
    task automatic t_clamp_std();
        drive_a(255, 0, 0, 1);
        @(negedge clk);
        drive_a(255, 255, 0, 1);
        @(negedge clk);
        drive_a(0, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R6", "red Cr overflow to max", int'(a_o2), 255);
        @(negedge clk);
        chk("R6", "yellow Cb underflow to min", int'(a_o1), 0);
        repeat (4) @(negedge clk);
    endtask

    // R2: single-cycle pulse lands exactly six cycles later and lasts one cycle
    task automatic t_pulse();
        drive_a(10, 20, 30, 1);
        @(negedge clk);
        drive_a(0, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R2", "pulse not early", int'(a_ovld), 0);
        @(negedge clk);
        chk("R2", "pulse on time", int'(a_ovld), 1);
        chk("R2", "pulse data c0", int'(a_o0), model_std(0, 10, 20, 30));
        @(negedge clk);
        chk("R2", "pulse one cycle", int'(a_ovld), 0);
        repeat (3) @(negedge clk);
    endtask

    // R2: run of four with a gap keeps its shape
    task automatic t_run();
        int first = -1;
        int count = 0;
        for (int i = 0; i < 18; i++) begin
            if (a_ovld) begin
                count++;
                if (first < 0) first = i;
            end
            if (i < 4 || i == 5) drive_a(i, i, i, 1);
            else                 drive_a(0, 0, 0, 0);
            @(negedge clk);
        end
        chk("R2", "run first index", first, 6);
        chk("R2", "run count", count, 5);
    endtask

    // R9: data advances with in_vld low
    task automatic t_free_running();
        drive_a(255, 255, 255, 0);
        @(negedge clk);
        drive_a(0, 0, 0, 0);
        repeat (5) @(negedge clk);
        chk("R9", "no qualifier", int'(a_ovld), 0);
        chk("R9", "unqualified c0", int'(a_o0), 255);
        chk("R9", "unqualified c1", int'(a_o1), 128);
        repeat (3) @(negedge clk);
    endtask

    // R5/R7/R6/R4/R3: signed input channel, signed output channel, custom windows
    task automatic t_signed();
        int d0 [4] = '{50, 700, 300, 1023};
        int d1 [4] = '{1019, 200, 724, 511};   // -5, 200, -300, 511 in 10-bit two's complement
        int d2 [4] = '{1, 100, 1023, 0};
        for (int i = 0; i < 10; i++) begin
            if (i >= 6) begin
                chk("R5", "sg vld", int'(b_ovld), 1);
                chk("R6", "sg c0 window", int'(b_o0), model_sg(0, d0[i-6], d1[i-6], d2[i-6]));
                chk("R5", "sg c1 signed in", int'(b_o1), model_sg(1, d0[i-6], d1[i-6], d2[i-6]));
                chk("R7", "sg c2 signed out", int'(b_o2), model_sg(2, d0[i-6], d1[i-6], d2[i-6]));
            end
            if (i < 4) drive_b(d0[i], d1[i], d2[i], 1);
            else       drive_b(0, 0, 0, 0);
            @(negedge clk);
        end
        // first vector: +5 + 0.5 + 40 rounds up to 46 (R4 half case, R3 offset scale)
        chk("R4", "half rounds up", model_sg(2, 50, 1019, 1), 46);
        repeat (4) @(negedge clk);
    endtask

    // R8: asynchronous reset in mid-stream
    task automatic t_reset_mid();
        drive_a(255, 255, 255, 1);
        repeat (8) @(negedge clk);
        chk("R8", "pre-reset vld", int'(a_ovld), 1);
        rst_n = 1'b0;
        #1;
        chk("R8", "async vld clear", int'(a_ovld), 0);
        chk("R8", "async c0 clear", int'(a_o0), 0);
        drive_a(0, 0, 0, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_stream_std();
        t_clamp_std();
        t_pulse();
        t_run();
        t_free_running();
        t_signed();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule